// File: doc/BRIEF.md
# Retimed Third-Order Recursive Filter

This block is a streaming all-pole filter on signed fixed-point samples. Each accepted input sample x(n) produces one output y(n) = a·y(n-2) + b·y(n-3) + x(n). The coefficients a and b are programmable inputs in a signed fractional format. The output is registered and comes with a valid flag one cycle after the sample that produced it.

The recursion can be built in two register arrangements, and a parameter picks one. In the direct form, one register holds the summed term a·y(n-1) + b·y(n-2) and feeds the next sample. In the retimed form, that single register is replaced by two registers, one behind each multiplier. Each holds a full-precision product. The output adder sums the two delayed products with the new sample. This costs one extra word of storage. In exchange, the path from any register back into the sample registers contains adders only. Both forms keep full product precision until a single final scaling, so their outputs are identical bit for bit.

The history advances only on cycles where a sample is offered. Idle cycles leave the filter state and the output value untouched.

Top module: `rf_recursive_filter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, out_valid is 0 and y_out is 0. All filter history is zero.
- R2: Coefficients are signed DATA-width values with FRAC = 14 fractional bits. Each output is computed as follows. Take the full-precision sum a·y(n-2) + b·y(n-3), arithmetically shift it right by FRAC (rounding toward minus infinity), add x(n), and keep the low 16 bits.
- R3: When in_valid is high at a rising clock edge, out_valid is high after that edge and y_out carries the result for that sample. The latency is exactly one cycle.
- R4: A cycle with in_valid low advances no history. After that edge out_valid is 0 and y_out keeps its previous value. The next accepted sample continues the recursion as if the idle cycle had not occurred.
- R5: The direct form (FORM = RF_FORM_DIRECT) and the retimed form (FORM = RF_FORM_RETIMED) give the same out_valid and y_out on every cycle for the same stimulus.
- R6: Results that do not fit in 16 bits wrap in two's complement. There is no saturation.
- R7: The products that feed y(n) use the coefficient values present on the cycle that accepted sample n-1. A coefficient change therefore first affects the output one accepted sample later.
- R8: Asserting reset in the middle of a stream clears all history. The first sample accepted after release gives y = x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| in_valid | input | 1 | A sample is offered this cycle |
| x_in | input | DATA_W | Signed input sample |
| coef_a | input | COEF_W | Signed coefficient on y(n-2), FRAC fractional bits |
| coef_b | input | COEF_W | Signed coefficient on y(n-3), FRAC fractional bits |
| out_valid | output | 1 | y_out holds a new result |
| y_out | output | DATA_W | Signed filter output |

## Verification
The filter is tried with the following input patterns:
- An impulse under positive coefficients. This exposes the two-sample gap in the recursion and any misplaced delay, because a wrong tap lands the echo on the wrong output.
- A step input and alternating-sign input under negative coefficients. These separate arithmetic from logical shifting and confirm floor rounding.
- Large coefficients with a full-scale input. This forces two's-complement wrap.
- Streams broken by idle cycles, a mid-stream coefficient change, and a mid-stream reset. These pin down state holding, coefficient capture timing and history clearing.

Both forms run side by side throughout, so any difference between the arrangements shows up on the first cycle where it occurs.

// File: rtl/rf_pkg.sv
package rf_pkg;
  typedef enum logic {
    RF_FORM_DIRECT  = 1'b0,
    RF_FORM_RETIMED = 1'b1
  } rf_form_e;
endpackage

// File: rtl/rf_mul.sv
module rf_mul #(
  parameter int A_W = 16,
  parameter int B_W = 16,
  localparam int P_W = A_W + B_W
) (
  input  logic signed [A_W-1:0] op_a,
  input  logic signed [B_W-1:0] op_b,
  output logic signed [P_W-1:0] prod
);
  always_comb begin
    prod = P_W'(op_a) * P_W'(op_b);
  end
endmodule

// File: rtl/rf_history.sv
module rf_history #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic signed [W-1:0] y_new,
  output logic signed [W-1:0] y_d1,
  output logic signed [W-1:0] y_d2
);
  logic signed [W-1:0] d1_nx;
  logic signed [W-1:0] d2_nx;

  always_comb begin
    d1_nx = y_d1;
    d2_nx = y_d2;
    if (en) begin
      d1_nx = y_new;
      d2_nx = y_d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_d1 <= '0;
      y_d2 <= '0;
    end else begin
      y_d1 <= d1_nx;
      y_d2 <= d2_nx;
    end
  end

  // R2: the older tap receives what the newer tap held
  p_hist_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (y_d2 == $past(y_d1)));

  // R4: no movement without an accepted sample
  p_hist_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(y_d1) && $stable(y_d2)));
endmodule

// File: rtl/rf_fb_direct.sv
module rf_fb_direct #(
  parameter int W  = 16,
  parameter int CW = 16,
  localparam int PW = W + CW,
  localparam int SW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [W-1:0]  y_d1,
  input  logic signed [W-1:0]  y_d2,
  output logic signed [SW-1:0] fb_sum
);
  logic signed [PW-1:0] prod_a;
  logic signed [PW-1:0] prod_b;
  logic signed [SW-1:0] sum_nx;

  rf_mul #(.A_W(CW), .B_W(W)) u_mul_a (.op_a(coef_a), .op_b(y_d1), .prod(prod_a));
  rf_mul #(.A_W(CW), .B_W(W)) u_mul_b (.op_a(coef_b), .op_b(y_d2), .prod(prod_b));

  always_comb begin
    sum_nx = fb_sum;
    if (en) begin
      sum_nx = SW'(prod_a) + SW'(prod_b);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_sum <= '0;
    end else begin
      fb_sum <= sum_nx;
    end
  end

  // R4: the summed term is frozen while no sample is offered
  p_sum_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fb_sum));
endmodule

// File: rtl/rf_fb_retimed.sv
module rf_fb_retimed #(
  parameter int W  = 16,
  parameter int CW = 16,
  localparam int PW = W + CW,
  localparam int SW = PW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  input  logic signed [W-1:0]  y_d1,
  input  logic signed [W-1:0]  y_d2,
  output logic signed [SW-1:0] fb_sum
);
  logic signed [PW-1:0] prod_a;
  logic signed [PW-1:0] prod_b;
  logic signed [PW-1:0] pa_q;
  logic signed [PW-1:0] pb_q;
  logic signed [PW-1:0] pa_nx;
  logic signed [PW-1:0] pb_nx;

  rf_mul #(.A_W(CW), .B_W(W)) u_mul_a (.op_a(coef_a), .op_b(y_d1), .prod(prod_a));
  rf_mul #(.A_W(CW), .B_W(W)) u_mul_b (.op_a(coef_b), .op_b(y_d2), .prod(prod_b));

  always_comb begin
    pa_nx = pa_q;
    pb_nx = pb_q;
    if (en) begin
      pa_nx = prod_a;
      pb_nx = prod_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q <= '0;
      pb_q <= '0;
    end else begin
      pa_q <= pa_nx;
      pb_q <= pb_nx;
    end
  end

  always_comb begin
    fb_sum = SW'(pa_q) + SW'(pb_q);
  end

  // R4: both delayed products are frozen while no sample is offered
  p_prod_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(pa_q) && $stable(pb_q)));

  // R7: each product register captures the product formed on the accepting cycle
  p_prod_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (pa_q == $past(prod_a)) && (pb_q == $past(prod_b)));
endmodule

// File: rtl/rf_recursive_filter.sv
module rf_recursive_filter
  import rf_pkg::*;
#(
  parameter int       DATA_W = 16,
  parameter int       COEF_W = 16,
  parameter int       FRAC   = 14,
  parameter rf_form_e FORM   = RF_FORM_RETIMED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] x_in,
  input  logic [COEF_W-1:0] coef_a,
  input  logic [COEF_W-1:0] coef_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] y_out
);
  localparam int PW = DATA_W + COEF_W;
  localparam int SW = PW + 1;
  localparam int TW = SW + 1;

  logic signed [DATA_W-1:0] x_s;
  logic signed [COEF_W-1:0] ca_s;
  logic signed [COEF_W-1:0] cb_s;
  logic signed [DATA_W-1:0] y_d1;
  logic signed [DATA_W-1:0] y_d2;
  logic signed [DATA_W-1:0] y_next;
  logic signed [SW-1:0]     fb_sum;
  logic signed [SW-1:0]     fb_scaled;
  logic signed [TW-1:0]     total;
  logic                     vld_nx;

  assign x_s  = $signed(x_in);
  assign ca_s = $signed(coef_a);
  assign cb_s = $signed(coef_b);

  generate
    if (FORM == RF_FORM_RETIMED) begin : g_retimed
      rf_fb_retimed #(.W(DATA_W), .CW(COEF_W)) u_fb (
        .clk(clk), .rst_n(rst_n), .en(in_valid),
        .coef_a(ca_s), .coef_b(cb_s),
        .y_d1(y_d1), .y_d2(y_d2), .fb_sum(fb_sum));
    end else begin : g_direct
      rf_fb_direct #(.W(DATA_W), .CW(COEF_W)) u_fb (
        .clk(clk), .rst_n(rst_n), .en(in_valid),
        .coef_a(ca_s), .coef_b(cb_s),
        .y_d1(y_d1), .y_d2(y_d2), .fb_sum(fb_sum));
    end
  endgenerate

  always_comb begin
    fb_scaled = fb_sum >>> FRAC;
    total     = TW'(fb_scaled) + TW'(x_s);
    y_next    = total[DATA_W-1:0];
  end

  rf_history #(.W(DATA_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .en(in_valid),
    .y_new(y_next), .y_d1(y_d1), .y_d2(y_d2));

  always_comb begin
    vld_nx = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_nx;
    end
  end

  assign y_out = y_d1;

  // R3: a result appears exactly one cycle after an accepted sample
  p_valid_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R4: idle cycle gives no valid and a held output
  p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(y_out)));

  // R3: the presented result is the value formed on the accepting cycle
  p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (y_out == $past(y_next)));
endmodule

// File: tb/sim_rf_recursive_filter.sv
module sim_rf_recursive_filter;
  import rf_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] x_in, coef_a, coef_b;
  logic        v0, v1;
  logic [15:0] y0, y1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  longint m_y1, m_y2, m_w;
  logic signed [15:0] exp_y;
  logic exp_v;

  always #2.5 clk = ~clk;

  rf_recursive_filter #(.FORM(RF_FORM_RETIMED)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
    .coef_a(coef_a), .coef_b(coef_b), .out_valid(v0), .y_out(y0));

  rf_recursive_filter #(.FORM(RF_FORM_DIRECT)) u1 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_in(x_in),
    .coef_a(coef_a), .coef_b(coef_b), .out_valid(v1), .y_out(y1));

  task automatic chk(string req, logic av, logic [15:0] ay);
    n_tests++;
    if (av !== exp_v || ay !== exp_y) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b y=%0d, expected valid=%0b y=%0d",
               req, av, $signed(ay), exp_v, exp_y);
    end
  endtask

  task automatic model_reset();
    m_y1 = 0; m_y2 = 0; m_w = 0;
    exp_v = 1'b0; exp_y = '0;
  endtask

  task automatic step(string req, bit v, int x, int a, int b);
    longint s;
    @(negedge clk);
    in_valid = v;
    x_in   = 16'(x);
    coef_a = 16'(a);
    coef_b = 16'(b);
    if (v) begin
      s = (m_w >>> 14) + longint'($signed(16'(x)));
      exp_y = 16'(s);
      m_w  = longint'($signed(16'(a))) * m_y1 + longint'($signed(16'(b))) * m_y2;
      m_y2 = m_y1;
      m_y1 = longint'(exp_y);
      exp_v = 1'b1;
    end else begin
      exp_v = 1'b0;
    end
    @(posedge clk);
    #1;
    chk(req, v0, y0);
    chk({req, " (direct form)"}, v1, y1);
    // R5: both arrangements agree cycle by cycle
    n_tests++;
    if (v0 !== v1 || y0 !== y1) begin
      n_fail++;
      $display("FAIL R5: retimed valid=%0b y=%0d, direct valid=%0b y=%0d",
               v0, $signed(y0), v1, $signed(y1));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk("R1", v0, y0);
    chk("R1", v1, y1);
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got no completion, expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; in_valid = 1'b0; x_in = '0; coef_a = '0; coef_b = '0;
    model_reset();
    do_reset();
    step("R1", 0, 0, 0, 0);

    // R2 / R3: impulse, a=0.5, b=0.25
    step("R2", 1, 1000, 8192, 4096);
    for (int i = 0; i < 10; i++) step("R2", 1, 0, 8192, 4096);

    // R4: idle gaps inside a step response
    for (int i = 0; i < 12; i++) begin
      step("R4", (i % 3) != 1, 700, 8192, 4096);
    end

    // R2: negative coefficients, alternating sign input (floor shift)
    for (int i = 0; i < 12; i++) step("R2", 1, (i % 2) ? -333 : 517, -6000, -7001);

    // R6: wrap on large coefficients and full-scale input
    for (int i = 0; i < 10; i++) step("R6", 1, 30000, 32767, 32767);

    // R7: coefficient change mid-stream
    for (int i = 0; i < 4; i++) step("R7", 1, 1200, 4096, 2048);
    for (int i = 0; i < 6; i++) step("R7", 1, 0, -12000, 9000);

    // R8: reset mid-stream, first result equals input
    do_reset();
    step("R8", 1, -4321, 8192, 8192);
    step("R8", 1, 0, 8192, 8192);
    step("R8", 1, 0, 8192, 8192);

    // R5: pseudo-random stream with random gaps
    lfsr = 16'hACE1;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R5", lfsr[3] | lfsr[7], $signed(lfsr), 6000, -3000);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule